// File: doc/BRIEF.md
# Deferred-Fault Speculative Load Tracker

This block records faults from speculative loads so that they are raised only when the program reaches the point where the loaded value is actually used. When a speculative load completes, it writes its destination register. If the memory access faulted, it leaves a deferred-fault mark on that register instead of trapping. A separate check operation later names the register. If the mark is present, the block raises an exception request. If the mark is absent, the check does nothing and execution goes on.

The block holds one deferred-fault bit for each general register, with 128 registers named by a 7-bit index. Three inputs change or read these bits:
- the load-completion port, which sets or clears a bit;
- the normal register-write port, which clears a bit;
- the check port, which reads a bit.

An exception request is a single-cycle registered pulse. It carries the index of the register that was checked. Register 0 never carries a mark.

Top module: `deferred_fault_tracker`

## Requirements
- R1: After reset, every deferred-fault bit is clear. While reset is active and in the first cycle after it, `excReq` is 0.
- R2: A load completion (`ldValid`=1) with `ldFault`=1 sets the bit of register `ldReg`. A later check of that register makes `excReq`=1 in the cycle after the check, with `excReg` equal to the checked index.
- R3: A load completion with `ldFault`=0 clears the bit of `ldReg`. A later check of that register gives `excReq`=0.
- R4: A normal write (`wrValid`=1) clears the bit of `wrReg`.
- R5: A check of a register whose bit is clear gives `excReq`=0 in the following cycle.
- R6: Each check cycle causes at most one cycle of `excReq`. `excReq` is never 1 in a cycle unless a check was presented in the cycle before it. A check leaves the bit unchanged, so repeated checks of a marked register each raise a request.
- R7: A check sees every update made in the same cycle. A same-cycle load to the checked register decides the result by its `ldFault`. A same-cycle normal write to the checked register makes the result "no exception".
- R8: Register 0 always reads as unmarked. A faulting load to register 0 is ignored, and a check of register 0 never raises `excReq`.
- R9: When a load completion and a normal write name the same register in the same cycle, the load completion decides the new bit value.
- R10: An update to one register leaves the bits of all other registers unchanged. This holds up to the highest index, 127.
- R11: `excReg` is 0 whenever `excReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | A speculative load completes this cycle |
| ldReg | input | 7 | Destination register of the completing load |
| ldFault | input | 1 | The completing load's memory access faulted |
| wrValid | input | 1 | A normal register write happens this cycle |
| wrReg | input | 7 | Destination register of the normal write |
| chkValid | input | 1 | A check operation executes this cycle |
| chkReg | input | 7 | Register named by the check |
| excReq | output | 1 | Deferred exception request, one-cycle pulse |
| excReg | output | 7 | Register index for the pending request, 0 when idle |

## Verification
The properties assume that `ldReg`, `wrReg` and `chkReg` are meaningful only while their valid strobes are high. They also assume that reset is asserted long enough to reach every mark flop.

The stimulus applies all inputs on the falling clock edge, so no value changes near the sampling edge. Index fields are zeroed whenever their strobe is low, so that idle cycles carry no stale indices. The same-cycle cases are driven on purpose with matching register indices, to exercise the forwarding path and the rule that a load wins over a normal write.

// File: rtl/dft_pkg.sv
package dft_pkg;
  parameter int NumRegs = 128;
  localparam int IdxW = $clog2(NumRegs);

  typedef struct packed {
    logic            ldEn;
    logic            ldFault;
    logic [IdxW-1:0] ldIdx;
    logic            wrEn;
    logic [IdxW-1:0] wrIdx;
  } dftStrobe_t;
endpackage

// File: rtl/dft_bits.sv
module dft_bits
  import dft_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dftStrobe_t      strb,
  input  logic [IdxW-1:0] rdIdx,
  output logic            rdBit
);
  logic [NumRegs-1:0] faultBits;

  for (genvar i = 0; i < NumRegs; i++) begin : g_bit
    if (i == 0) begin : g_zero
      assign faultBits[i] = 1'b0;
    end else begin : g_flop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          faultBits[i] <= 1'b0;
        else if (strb.ldEn && strb.ldIdx == IdxW'(i))
          faultBits[i] <= strb.ldFault;
        else if (strb.wrEn && strb.wrIdx == IdxW'(i))
          faultBits[i] <= 1'b0;
      end
    end
  end

  assign rdBit = faultBits[rdIdx];

  AST_SET_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldEn && strb.ldFault && strb.ldIdx != '0) |=> faultBits[$past(strb.ldIdx)]); // R2
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldEn && !strb.ldFault) |=> !faultBits[$past(strb.ldIdx)]); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !(strb.ldEn && strb.ldIdx == strb.wrIdx)) |=> !faultBits[$past(strb.wrIdx)]); // R4
  AST_ZERO_UNMARKED: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == '0) |-> !rdBit); // R8
endmodule

// File: rtl/dft_ctrl.sv
module dft_ctrl
  import dft_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic [IdxW-1:0] ldReg,
  input  logic            ldFault,
  input  logic            wrValid,
  input  logic [IdxW-1:0] wrReg,
  input  logic            chkValid,
  input  logic [IdxW-1:0] chkReg,
  input  logic            rdBit,
  output dftStrobe_t      strb,
  output logic [IdxW-1:0] rdIdx,
  output logic            excReq,
  output logic [IdxW-1:0] excReg
);
  logic ldHit;
  logic wrHit;
  logic markNow;

  always_comb begin
    strb.ldEn    = ldValid && (ldReg != '0);
    strb.ldFault = ldFault;
    strb.ldIdx   = ldReg;
    strb.wrEn    = wrValid && (wrReg != '0);
    strb.wrIdx   = wrReg;
  end

  assign rdIdx = chkReg;
  assign ldHit = strb.ldEn && (ldReg == chkReg);
  assign wrHit = strb.wrEn && (wrReg == chkReg);

  always_comb begin
    if (chkReg == '0)
      markNow = 1'b0;
    else if (ldHit)
      markNow = ldFault;
    else if (wrHit)
      markNow = 1'b0;
    else
      markNow = rdBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excReq <= 1'b0;
      excReg <= '0;
    end else if (chkValid && markNow) begin
      excReq <= 1'b1;
      excReg <= chkReg;
    end else begin
      excReq <= 1'b0;
      excReg <= '0;
    end
  end

  AST_EXC_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(chkValid)); // R6
  AST_EXC_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excReg == $past(chkReg))); // R2
  AST_ZERO_NO_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkReg == '0) |=> !excReq); // R8
  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |-> (excReg == '0)); // R11
  AST_SAME_CYCLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && ldValid && ldReg == chkReg && chkReg != '0) |=> (excReq == $past(ldFault))); // R7
endmodule

// File: rtl/deferred_fault_tracker.sv
module deferred_fault_tracker
  import dft_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic [IdxW-1:0] ldReg,
  input  logic            ldFault,
  input  logic            wrValid,
  input  logic [IdxW-1:0] wrReg,
  input  logic            chkValid,
  input  logic [IdxW-1:0] chkReg,
  output logic            excReq,
  output logic [IdxW-1:0] excReg
);
  dftStrobe_t      strb;
  logic [IdxW-1:0] rdIdx;
  logic            rdBit;

  dft_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldReg(ldReg), .ldFault(ldFault),
    .wrValid(wrValid), .wrReg(wrReg),
    .chkValid(chkValid), .chkReg(chkReg),
    .rdBit(rdBit), .strb(strb), .rdIdx(rdIdx),
    .excReq(excReq), .excReg(excReg)
  );

  dft_bits u_bits (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdIdx(rdIdx), .rdBit(rdBit)
  );
endmodule

// File: tb/deferred_fault_tracker_bench.sv
module deferred_fault_tracker_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       ldValid, ldFault, wrValid, chkValid;
  logic [6:0] ldReg, wrReg, chkReg;
  logic       excReq;
  logic [6:0] excReg;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  deferred_fault_tracker u_deferred_fault_tracker (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldReg(ldReg), .ldFault(ldFault),
    .wrValid(wrValid), .wrReg(wrReg),
    .chkValid(chkValid), .chkReg(chkReg),
    .excReq(excReq), .excReg(excReg)
  );

  task automatic cyc(input logic lv, input logic [6:0] lr, input logic lf,
                     input logic wv, input logic [6:0] wr,
                     input logic cv, input logic [6:0] cr);
    @(negedge clk);
    ldValid = lv; ldReg = lv ? lr : 7'd0; ldFault = lv ? lf : 1'b0;
    wrValid = wv; wrReg = wv ? wr : 7'd0;
    chkValid = cv; chkReg = cv ? cr : 7'd0;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic expE, input logic [6:0] expR, input string req);
    checks++;
    if (excReq !== expE || excReg !== expR) begin
      errors++;
      $display("FAIL %s: excReq=%0b excReg=%0d expected excReq=%0b excReg=%0d",
               req, excReq, excReg, expE, expR);
    end
  endtask

  task automatic load(input logic [6:0] r, input logic f);
    cyc(1, r, f, 0, 0, 0, 0);
  endtask

  task automatic wrt(input logic [6:0] r);
    cyc(0, 0, 0, 1, r, 0, 0);
  endtask

  task automatic chk(input logic [6:0] r, input logic expE, input string req);
    cyc(0, 0, 0, 0, 0, 1, r);
    expect_out(expE, expE ? r : 7'd0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    ldValid = 0; ldReg = 0; ldFault = 0; wrValid = 0; wrReg = 0; chkValid = 0; chkReg = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    expect_out(0, 0, "R1 idle after reset");
    chk(7'd5, 0, "R1 reg5 unmarked after reset");
    chk(7'd127, 0, "R1 reg127 unmarked after reset");
  endtask

  task automatic t_fault();
    load(7'd10, 1);
    expect_out(0, 0, "R6 no request from load alone");
    chk(7'd10, 1, "R2 marked reg10 raises request");
    chk(7'd10, 1, "R6 check leaves mark in place");
    cyc(0, 0, 0, 0, 0, 0, 0);
    expect_out(0, 0, "R6 single-cycle pulse");
    expect_out(0, 0, "R11 index zero when idle");
  endtask

  task automatic t_nonfault();
    load(7'd10, 0);
    chk(7'd10, 0, "R3 clean load clears mark");
  endtask

  task automatic t_write();
    load(7'd20, 1);
    wrt(7'd20);
    chk(7'd20, 0, "R4 normal write clears mark");
    chk(7'd99, 0, "R5 never-marked reg99");
  endtask

  task automatic t_bypass();
    cyc(1, 7'd30, 1, 0, 0, 1, 7'd30);
    expect_out(1, 7'd30, "R7 same-cycle faulting load seen");
    load(7'd31, 1);
    cyc(1, 7'd31, 0, 0, 0, 1, 7'd31);
    expect_out(0, 0, "R7 same-cycle clean load seen");
    load(7'd32, 1);
    cyc(0, 0, 0, 1, 7'd32, 1, 7'd32);
    expect_out(0, 0, "R7 same-cycle write seen");
  endtask

  task automatic t_reg0();
    load(7'd0, 1);
    chk(7'd0, 0, "R8 reg0 ignores faulting load");
    cyc(1, 7'd0, 1, 0, 0, 1, 7'd0);
    expect_out(0, 0, "R8 reg0 same-cycle");
  endtask

  task automatic t_priority();
    cyc(1, 7'd40, 1, 1, 7'd40, 0, 0);
    chk(7'd40, 1, "R9 load wins over write");
  endtask

  task automatic t_indep();
    load(7'd50, 1);
    load(7'd127, 1);
    load(7'd51, 0);
    chk(7'd50, 1, "R10 reg50 marked");
    chk(7'd127, 1, "R10 top index marked");
    chk(7'd51, 0, "R10 reg51 clean");
    wrt(7'd50);
    chk(7'd127, 1, "R10 reg127 kept after reg50 write");
    chk(7'd30, 1, "R10 reg30 kept");
    chk(7'd50, 0, "R4 reg50 cleared");
  endtask

  task automatic t_reset_mid();
    do_reset();
    #1;
    chk(7'd127, 0, "R1 reset clears reg127");
    chk(7'd30, 0, "R1 reset clears reg30");
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fault();
    t_nonfault();
    t_write();
    t_bypass();
    t_reg0();
    t_priority();
    t_indep();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule